// File: doc/BRIEF.md
# Watchdog Fail-Safe Output Controller

This block is the digital core that decides whether a smart load switch drives its load. It chooses among three sources for the output-enable. The first is a level written into a small configuration register by the serial host. The second is a direct parallel input, which is fast enough to carry a PWM waveform. The third is a fail-safe level set by a strap, which is used when the host stops servicing the watchdog.

The watchdog is armed in one of two ways: the chip leaves sleep, or the wake input is high. A ground strap turns the watchdog off. When it expires, the output is forced to the strapped ON or OFF level until the host writes again or the chip goes back through sleep.

A set of fault flags overrides every source. Each flag is latched, pulls the active-low fault pin down, and stays visible in the status word until the host clears it. Two resets are used:
- `rst_ni` models loss of the logic supply and clears everything.
- `sleep_ni` is the sleep/reset pin. It clears the configuration and the fault latch while it is low.

Top module: `wdfs_out_ctrl`

## Requirements
- R1: While `sleep_ni` is low and the watchdog has not timed out, `out_en_o` is 0, the configuration and fault latch are cleared, and a status source of 0 is reported. `rst_ni` low clears every register, including the timeout flag.
- R2: Release of `sleep_ni` passes through a two-flop synchroniser and then restarts the watchdog. With `wake_i` low, `status_o[2]` (timeout) rises exactly `TIMEOUT_CYC`+3 clock edges after the release, if no write arrives.
- R3: Strap code 2'b00 (tied to ground) disables the watchdog. The timeout flag is clear one edge after the strap reads 2'b00, and it never sets while the strap stays 2'b00.
- R4: After a timeout with no latched fault, `out_en_o` is 0 for strap 2'b01 and 1 for straps 2'b10 and 2'b11, whatever the configuration.
- R5: Configuration bit 1 set makes `out_en_o` follow `dir_i`, delayed by two synchroniser flops. With bit 1 clear, `out_en_o` equals configuration bit 0.
- R6: A write (`wr_vld_i` high while the block is out of sleep) clears the timeout flag at that edge and restarts the count. The flag then rises again `TIMEOUT_CYC` edges later. A sleep pulse also ends a timeout.
- R7: With `wake_i` high, the watchdog runs even while `sleep_ni` is low. With `wake_i` low during sleep, it stays idle and the timeout flag clears.
- R8: Any set bit of `flt_i` is latched one edge later. While any latched bit is set, `out_en_o` is 0 (including under fail-safe ON), `fault_no` is 0, and the latched bits appear in `status_o[NUM_FLT+2:3]`.
- R9: A `flt_clr_i` pulse reloads the latch with the current `flt_i`. Bits that are still asserted therefore survive the clear.
- R10: Writes issued while `sleep_ni` is low are ignored.
- R11: `status_o[1:0]` gives the active source: 0 = off or fault, 1 = register level, 2 = direct input, 3 = fail-safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous logic-supply reset, active low |
| sleep_ni | input | 1 | Sleep/reset pin; asynchronous clear, synchronised release |
| wake_i | input | 1 | Wake level, enables the watchdog |
| strap_i | input | 2 | Fail-safe strap: 00 disabled, 01 OFF, 1x ON |
| dir_i | input | 1 | Direct/PWM control input |
| wr_vld_i | input | 1 | Valid configuration write strobe; also the watchdog refresh |
| wr_data_i | input | 2 | Write data: bit 1 follow direct input, bit 0 register level |
| flt_i | input | NUM_FLT | Detected fault flags |
| flt_clr_i | input | 1 | Fault latch clear (read) strobe |
| out_en_o | output | 1 | Load output enable |
| fault_no | output | 1 | Fault pin, low while any fault is latched |
| status_o | output | NUM_FLT+3 | {latched faults, timeout, source[1:0]} |

## Verification
The output is swept over every pair of configuration word and direct-input level. This separates register control from direct control and shows the synchroniser delay. A second sweep crosses all four strap codes with every configuration, letting the watchdog expire each time; it tells the disabled, forced-OFF and forced-ON cases apart from the configured level. The exact expiry edge is checked for both a sleep release and a host write. Wake during sleep, writes during sleep, and a fault that arrives under fail-safe ON confirm which source wins.

// File: rtl/wdfs_pkg.sv
package wdfs_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SPI = 2'd1,
    SRC_DIR = 2'd2,
    SRC_FS  = 2'd3
  } src_e;

  localparam logic [1:0] STRAP_GND = 2'b00;
  localparam logic [1:0] STRAP_OFF = 2'b01;
  localparam int unsigned CFG_ON  = 0;
  localparam int unsigned CFG_DIR = 1;
  localparam int unsigned CFG_W   = 2;
endpackage

// File: rtl/wdfs_sync.sv
module wdfs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/wdfs_wdog.sv
module wdfs_wdog #(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic kick_i,
  output logic to_o
);
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else if (!en_i || kick_i) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else if (!to_o) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        to_o  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdfs_flt.sv
module wdfs_flt #(
  parameter int unsigned NUM_FLT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FLT-1:0] set_i,
  input  logic               clr_i,
  output logic [NUM_FLT-1:0] q_o
);
  // clear reloads live faults so an active one is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= set_i;
    else            q_o <= q_o | set_i;
  end
endmodule

// File: rtl/wdfs_out_ctrl.sv
module wdfs_out_ctrl
  import wdfs_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned NUM_FLT     = 4,
  localparam int unsigned STAT_W     = NUM_FLT + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_ni,
  input  logic               wake_i,
  input  logic [1:0]         strap_i,
  input  logic               dir_i,
  input  logic               wr_vld_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  input  logic [NUM_FLT-1:0] flt_i,
  input  logic               flt_clr_i,
  output logic               out_en_o,
  output logic               fault_no,
  output logic [STAT_W-1:0]  status_o
);
  logic               arst_n;
  logic               run, run_d, run_rise, started;
  logic [1:0]         isync_q;
  logic               wake_s, dir_s;
  logic               wr_ok, kick, wd_en, wd_to;
  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_FLT-1:0] flt_q;
  src_e               src;

  // sleep pin clears config and faults asynchronously
  assign arst_n = rst_ni & sleep_ni;

  wdfs_sync #(.W(1)) u_rsync (
    .clk_i (clk_i),
    .rst_ni(arst_n),
    .d_i   (1'b1),
    .q_o   (run)
  );

  wdfs_sync #(.W(2)) u_isync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wake_i, dir_i}),
    .q_o   (isync_q)
  );
  assign wake_s = isync_q[1];
  assign dir_s  = isync_q[0];

  assign run_rise = run & ~run_d;
  assign wr_ok    = wr_vld_i & run;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      run_d   <= 1'b0;
      started <= 1'b0;
      cfg_q   <= '0;
    end else begin
      run_d   <= run;
      started <= started | run_rise;
      if (wr_ok) cfg_q <= wr_data_i;
    end
  end

  assign wd_en = (strap_i != STRAP_GND) & (wake_s | started);
  assign kick  = wr_ok | run_rise;

  wdfs_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (wd_en),
    .kick_i(kick),
    .to_o  (wd_to)
  );

  wdfs_flt #(.NUM_FLT(NUM_FLT)) u_flt (
    .clk_i (clk_i),
    .rst_ni(arst_n),
    .set_i (flt_i),
    .clr_i (flt_clr_i),
    .q_o   (flt_q)
  );

  // priority: fault, fail-safe, sleep, direct, register
  always_comb begin
    src      = SRC_OFF;
    out_en_o = 1'b0;
    if (|flt_q) begin
      src      = SRC_OFF;
      out_en_o = 1'b0;
    end else if (wd_to) begin
      src      = SRC_FS;
      out_en_o = (strap_i != STRAP_OFF);
    end else if (run) begin
      if (cfg_q[CFG_DIR]) begin
        src      = SRC_DIR;
        out_en_o = dir_s;
      end else begin
        src      = SRC_SPI;
        out_en_o = cfg_q[CFG_ON];
      end
    end
  end

  assign fault_no = ~|flt_q;
  assign status_o = {flt_q, wd_to, src};
endmodule

// File: rtl/wdfs_out_ctrl_chk.sv
module wdfs_out_ctrl_chk #(
  parameter int unsigned NUM_FLT = 4,
  localparam int unsigned STAT_W = NUM_FLT + 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        strap_i,
  input logic              wr_vld_i,
  input logic              run_i,
  input logic              out_en_o,
  input logic              fault_no,
  input logic [STAT_W-1:0] status_o
);
  logic any_flt, to;
  assign any_flt = |status_o[STAT_W-1:3];
  assign to      = status_o[2];

  AST_SLEEP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !to) |-> !out_en_o);                                   // R1
  AST_GND_NO_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_i == 2'b00) |=> !status_o[2]);                             // R3
  AST_FS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_i == 2'b01 && to) |-> !out_en_o);                          // R4
  AST_FS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_i[1] && to && !any_flt) |-> out_en_o);                     // R4
  AST_WR_CLEARS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && run_i) |=> !status_o[2]);                            // R6
  AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_flt |-> (!out_en_o && !fault_no));                            // R8
endmodule

bind wdfs_out_ctrl wdfs_out_ctrl_chk #(.NUM_FLT(NUM_FLT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strap_i (strap_i),
  .wr_vld_i(wr_vld_i),
  .run_i   (run),
  .out_en_o(out_en_o),
  .fault_no(fault_no),
  .status_o(status_o)
);

// File: tb/wdfs_out_ctrl_bench.sv
module wdfs_out_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int T     = 16;
  localparam int NF    = 2;

  logic          clk = 1'b0;
  logic          rst_n, sleep_n, wake, dir, wr_vld, flt_clr;
  logic [1:0]    strap, wr_data;
  logic [NF-1:0] flt;
  logic          out_en, fault_n;
  logic [NF+2:0] status;
  int            checks = 0;
  int            errors = 0;

  always #(CLK_P/2) clk = ~clk;

  wdfs_out_ctrl #(.TIMEOUT_CYC(T), .NUM_FLT(NF)) u_wdfs_out_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .wake_i(wake),
    .strap_i(strap), .dir_i(dir), .wr_vld_i(wr_vld), .wr_data_i(wr_data),
    .flt_i(flt), .flt_clr_i(flt_clr), .out_en_o(out_en), .fault_no(fault_n),
    .status_o(status)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] d);
    wr_vld = 1'b1; wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
  endtask

  task automatic boot(logic [1:0] s);
    strap = s; wake = 1'b0; sleep_n = 1'b0;
    tick(2);
    sleep_n = 1'b1;
    tick(4);
  endtask

  // level and source expected from the requirements
  function automatic int exp_out(logic to, logic [1:0] s, logic [1:0] c, logic d);
    if (to) return (s != 2'b01) ? 1 : 0;
    return c[1] ? int'(d) : int'(c[0]);
  endfunction
  function automatic int exp_src(logic to, logic [1:0] c);
    if (to) return 3;
    return c[1] ? 2 : 1;
  endfunction

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_n = 1'b0; wake = 1'b0; dir = 1'b0; wr_vld = 1'b0;
    wr_data = 2'b00; flt = '0; flt_clr = 1'b0; strap = 2'b01;
    tick(3);
    chk("R1 reset out", int'(out_en), 0);
    chk("R1 reset fault pin", int'(fault_n), 1);
    chk("R1 reset status", int'(status), 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 sleep out", int'(out_en), 0);
    chk("R11 sleep source", int'(status[1:0]), 0);

    // R2 exact expiry after sleep release
    sleep_n = 1'b1;
    tick(T + 2);
    chk("R2 no timeout yet", int'(status[2]), 0);
    tick(1);
    chk("R2 timeout edge", int'(status[2]), 1);
    chk("R4 fail-safe OFF out", int'(out_en), 0);
    chk("R11 fail-safe source", int'(status[1:0]), 3);

    // R6 write leaves timeout and restarts count
    wr(2'b01);
    chk("R6 write clears timeout", int'(status[2]), 0);
    chk("R6 write output", int'(out_en), 1);
    tick(T - 1);
    chk("R6 restart no timeout", int'(status[2]), 0);
    tick(1);
    chk("R6 restart timeout", int'(status[2]), 1);
    chk("R4 forced OFF over config", int'(out_en), 0);
    sleep_n = 1'b0;
    tick(4);
    chk("R6 sleep pulse clears timeout", int'(status[2]), 0);
    chk("R1 sleep out after timeout", int'(out_en), 0);

    // R5 config x direct sweep
    boot(2'b00);
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        dir = d[0];
        wr(c[1:0]);
        tick(2);
        chk("R5 output source select", int'(out_en), exp_out(1'b0, 2'b00, c[1:0], d[0]));
        chk("R11 source code", int'(status[1:0]), exp_src(1'b0, c[1:0]));
      end
    end

    // R3 ground strap never times out
    tick(3 * T);
    chk("R3 ground strap timeout", int'(status[2]), 0);
    chk("R3 ground strap output", int'(out_en), 1);

    // R4 strap x config sweep through expiry
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        boot(s[1:0]);
        dir = 1'b1;
        wr(c[1:0]);
        tick(T + 1);
        chk("R3 R4 timeout flag", int'(status[2]), (s != 0) ? 1 : 0);
        chk("R4 output after expiry", int'(out_en), exp_out(s != 0, s[1:0], c[1:0], 1'b1));
        chk("R11 source after expiry", int'(status[1:0]), exp_src(s != 0, c[1:0]));
      end
    end

    // R7 wake runs watchdog during sleep
    strap = 2'b10; sleep_n = 1'b0; wake = 1'b1;
    tick(T + 6);
    chk("R7 wake timeout in sleep", int'(status[2]), 1);
    chk("R7 fail-safe ON in sleep", int'(out_en), 1);
    wake = 1'b0;
    tick(4);
    chk("R7 wake low clears", int'(status[2]), 0);
    tick(2 * T);
    chk("R7 idle in sleep", int'(status[2]), 0);
    chk("R7 idle out", int'(out_en), 0);

    // R10 write during sleep ignored
    strap = 2'b00;
    wr(2'b01);
    sleep_n = 1'b1;
    tick(4);
    chk("R10 sleep write ignored out", int'(out_en), 0);
    chk("R10 sleep write source", int'(status[1:0]), 1);

    // R8 R9 fault latch
    wr(2'b01);
    chk("R8 pre-fault out", int'(out_en), 1);
    flt = 2'b10;
    tick(1);
    flt = 2'b00;
    chk("R8 fault forces off", int'(out_en), 0);
    chk("R8 fault pin low", int'(fault_n), 0);
    chk("R8 fault bits", int'(status[4:3]), 2);
    chk("R11 fault source", int'(status[1:0]), 0);
    tick(3);
    chk("R8 fault held", int'(status[4:3]), 2);
    flt_clr = 1'b1;
    tick(1);
    flt_clr = 1'b0;
    chk("R9 clear releases pin", int'(fault_n), 1);
    chk("R9 clear restores out", int'(out_en), 1);
    flt = 2'b01;
    tick(1);
    flt_clr = 1'b1;
    tick(1);
    flt_clr = 1'b0;
    chk("R9 live fault survives clear", int'(status[4:3]), 1);
    flt = 2'b00;
    flt_clr = 1'b1;
    tick(1);
    flt_clr = 1'b0;
    chk("R9 clear after drop", int'(status[4:3]), 0);

    // R8 fault overrides fail-safe ON
    boot(2'b10);
    tick(T + 1);
    chk("R4 fail-safe ON", int'(out_en), 1);
    flt = 2'b01;
    tick(1);
    flt = 2'b00;
    chk("R8 fault over fail-safe", int'(out_en), 0);
    flt_clr = 1'b1;
    tick(1);
    flt_clr = 1'b0;
    chk("R8 fail-safe back", int'(out_en), 1);

    // R1 supply loss clears all
    rst_n = 1'b0;
    tick(1);
    chk("R1 supply loss status", int'(status), 0);
    chk("R1 supply loss out", int'(out_en), 0);
    rst_n = 1'b1;
    tick(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule